// File: doc/BRIEF.md
# Clock Root Selector with Half-Step Divider

This block generates the enable for one clock root inside a larger clocking tree. Several source clocks reach it as one-cycle enable pulses in the system clock domain, one pulse per source period. The block picks one source and divides its pulse train by a ratio that can be an integer or an integer plus one half. It emits an output enable pulse train at the resulting rate.

Software controls the block through a small word-addressed register port. It first writes the wanted source and divider code into a configuration register. The new setting then waits as a pending value until software sets a command bit that requests an update. The block adopts the pending setting at the end of a complete output frame, so that no shortened phase ever reaches the output. It then clears the request by itself. A dirty flag shows that a written setting has not yet been applied. A root-off flag shows that the selected source has stopped.

When the selected source has stopped, nothing can glitch. A pending update is then applied on the next cycle, which lets software steer away from a dead source.

Top module: `clkroot_mux_div`

## Requirements
- R1: After reset the command word reads 0 (no update request, not dirty, root running), and the configuration word reads source 0 with divider code 1.
- R2: The command word is at offset 0x0 and the configuration word at offset 0x4. In the command word, bit 0 is the update request, bit 4 is the dirty flag and bit 31 is the root-off flag. In the configuration word, bits [4:0] hold the divider code and bits [10:8] hold the source index. All other bits read 0 and ignore writes, and any other offset reads 0.
- R3: A configuration write changes only the pending setting, and a read of offset 0x4 returns that pending setting. The output keeps its previous rate until an update is applied.
- R4: The dirty flag sets on a configuration write whose value differs from the pending setting. A write of the same value leaves it unchanged. It clears in the cycle in which the update request clears.
- R5: Writing 1 to command bit 0 sets the update request. Writing 0 there has no effect, and writes to bits 4 and 31 have no effect.
- R6: With divider code f (code 0 is treated as 1), let N = f+1. A frame spans N ticks of the selected source and contains two output pulses. For even N, the pulses come after N/2 and after N ticks. For odd N, the short phase (floor(N/2) ticks) comes first and the long phase follows. The output rate is therefore 2·source/(f+1).
- R7: A pending update is applied only on the source tick that closes a frame. Counting with the new source and divider starts at the next tick, and the update request and dirty flag clear in that same cycle.
- R8: Only ticks of the active source advance the divider. An index with no source behind it (4 to 7 when four sources exist) produces no output pulses.
- R9: The root-off flag (register bit and port) rises after 16 consecutive cycles without a tick of the active source and falls on the next such tick. While it is high the output is quiet, and a pending update is applied in the following cycle without waiting for a frame end.
- R10: Each output pulse lasts one cycle and appears in the cycle after the source tick that closes a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_en_i | input | 4 | One tick pulse per source period, one bit per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| out_en_o | output | 1 | Divided output enable pulse |
| root_off_o | output | 1 | Active source has stopped |
| dirty_o | output | 1 | Written setting not yet applied |

## Verification
The bench works through the odd ratios, where a design that put the long phase first or that reset the phase counter in mid-frame would shift pulses by one tick. It sets the update request in mid-frame and checks that the new setting takes effect only after the closing tick. An early switch would produce a runt pulse, and a late switch would lose a whole frame. It writes a setting equal to the pending one and checks that the dirty flag stays low, since a design that sets the flag on every write would raise it there. It also selects a source index with no source behind it, lets the root stop, and then checks that a redirecting update is applied without a frame end. A design that waited for a frame end at that point would never clear the update request.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam logic [3:0]  OFS_CMD   = 4'h0;
  localparam logic [3:0]  OFS_CFG   = 4'h4;
  localparam int unsigned BIT_UPD   = 0;
  localparam int unsigned BIT_DIRTY = 4;
  localparam int unsigned BIT_ROFF  = 31;
endpackage

// File: rtl/clkroot_regs.sv
module clkroot_regs
  import clkroot_pkg::*;
#(
  parameter int unsigned SRC_W  = 3,
  parameter int unsigned DIV_W  = 5,
  parameter int unsigned SRC_SH = 8,
  parameter int unsigned DIV_SH = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              frame_end_i,
  input  logic              root_off_i,
  output logic [SRC_W-1:0]  act_src_o,
  output logic [DIV_W-1:0]  act_div_o,
  output logic              apply_o,
  output logic              upd_o,
  output logic              dirty_o,
  output logic              cfg_we_o
);
  logic [SRC_W-1:0] pend_src_q, act_src_q, new_src;
  logic [DIV_W-1:0] pend_div_q, act_div_q, new_div;
  logic upd_q, upd_d, dirty_q, dirty_d;
  logic cmd_we, cfg_we, changed, apply;

  always_comb begin
    cmd_we  = we_i && (addr_i == OFS_CMD);
    cfg_we  = we_i && (addr_i == OFS_CFG);
    new_src = wdata_i[SRC_SH +: SRC_W];
    new_div = wdata_i[DIV_SH +: DIV_W];
    changed = cfg_we && ((new_src != pend_src_q) || (new_div != pend_div_q));
    apply   = upd_q && (frame_end_i || root_off_i);
    upd_d   = upd_q;
    if (apply) upd_d = 1'b0;
    if (cmd_we && wdata_i[BIT_UPD]) upd_d = 1'b1;
    dirty_d = dirty_q;
    if (apply) dirty_d = 1'b0;
    if (changed) dirty_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      upd_q   <= upd_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_src_q <= '0;
      pend_div_q <= DIV_W'(1);
    end else if (cfg_we) begin
      pend_src_q <= new_src;
      pend_div_q <= new_div;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_src_q <= '0;
      act_div_q <= DIV_W'(1);
    end else if (apply) begin
      act_src_q <= pend_src_q;
      act_div_q <= pend_div_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CMD) begin
      rdata_o[BIT_UPD]   = upd_q;
      rdata_o[BIT_DIRTY] = dirty_q;
      rdata_o[BIT_ROFF]  = root_off_i;
    end else if (addr_i == OFS_CFG) begin
      rdata_o[SRC_SH +: SRC_W] = pend_src_q;
      rdata_o[DIV_SH +: DIV_W] = pend_div_q;
    end
  end

  assign act_src_o = act_src_q;
  assign act_div_o = act_div_q;
  assign apply_o   = apply;
  assign upd_o     = upd_q;
  assign dirty_o   = dirty_q;
  assign cfg_we_o  = cfg_we;
endmodule

// File: rtl/clkroot_divider.sv
module clkroot_divider #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             out_en_o,
  output logic             frame_end_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [CW-1:0] span, half_last, frame_last, cnt_q, cnt_d;
  logic hit, cnt_en, out_q;

  always_comb begin
    span        = (div_i == '0) ? CW'(2) : CW'(div_i) + CW'(1);
    half_last   = (span >> 1) - CW'(1);
    frame_last  = span - CW'(1);
    frame_end_o = tick_i && (cnt_q == frame_last);
    hit         = tick_i && ((cnt_q == half_last) || (cnt_q == frame_last));
    cnt_en      = tick_i || restart_i;
    if (restart_i || frame_end_o) cnt_d = '0;
    else                          cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= hit;
  end

  assign out_en_o = out_q;
endmodule

// File: rtl/clkroot_activity.sv
module clkroot_activity #(
  parameter int unsigned TMO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic root_off_o
);
  localparam int unsigned IW = $clog2(TMO + 1);

  logic [IW-1:0] idle_q, idle_d;
  logic idle_en, at_limit;

  always_comb begin
    at_limit = (idle_q == IW'(TMO));
    idle_en  = tick_i || restart_i || !at_limit;
    idle_d   = (tick_i || restart_i) ? '0 : idle_q + IW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idle_q <= '0;
    else if (idle_en) idle_q <= idle_d;
  end

  assign root_off_o = at_limit;
endmodule

// File: rtl/clkroot_mux_div.sv
module clkroot_mux_div
  import clkroot_pkg::*;
#(
  parameter int unsigned NSRC     = 4,
  parameter int unsigned SRC_W    = 3,
  parameter int unsigned DIV_W    = 5,
  parameter int unsigned SRC_SH   = 8,
  parameter int unsigned DIV_SH   = 0,
  parameter int unsigned ROOT_TMO = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              out_en_o,
  output logic              root_off_o,
  output logic              dirty_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [SRC_W-1:0] act_src_w;
  logic [DIV_W-1:0] act_div_w;
  logic tick_w, apply_w, upd_w, dirty_w, cfg_we_w, frame_end_w, root_off_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    tick_w = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (act_src_w == SRC_W'(i)) tick_w = src_en_i[i];
    end
  end

  clkroot_regs #(
    .SRC_W(SRC_W), .DIV_W(DIV_W), .SRC_SH(SRC_SH), .DIV_SH(DIV_SH)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_int_n),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .frame_end_i(frame_end_w), .root_off_i(root_off_w),
    .act_src_o(act_src_w), .act_div_o(act_div_w),
    .apply_o(apply_w), .upd_o(upd_w), .dirty_o(dirty_w), .cfg_we_o(cfg_we_w)
  );

  clkroot_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_int_n),
    .tick_i(tick_w), .restart_i(apply_w), .div_i(act_div_w),
    .out_en_o(out_en_o), .frame_end_o(frame_end_w)
  );

  clkroot_activity #(.TMO(ROOT_TMO)) u_act (
    .clk_i(clk_i), .rst_ni(rst_int_n),
    .tick_i(tick_w), .restart_i(apply_w), .root_off_o(root_off_w)
  );

  assign root_off_o = root_off_w;
  assign dirty_o    = dirty_w;
endmodule

// File: rtl/clkroot_mux_div_chk.sv
module clkroot_mux_div_chk #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned SRC_W = 3,
  parameter int unsigned DIV_W = 5
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_en,
  input logic             out_en,
  input logic             upd,
  input logic             dirty,
  input logic             cfg_we,
  input logic             frame_end,
  input logic             root_off,
  input logic [SRC_W-1:0] act_src,
  input logic [DIV_W-1:0] act_div
);
  // R10: a pulse is always preceded by a source tick
  assert_pulse_follows_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_en |-> $past(|src_en));

  // R7: active setting moves only at a frame end or while the root is off
  assert_switch_on_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!$stable(act_src) || !$stable(act_div)) |-> $past(frame_end || root_off));

  // R5: the update request drops only when it could be applied
  assert_request_held_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(upd) |-> $past(frame_end || root_off));

  // R4: dirty is gone once the request has cleared, barring a fresh write
  assert_dirty_with_request_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($fell(upd) && !$past(cfg_we)) |-> !dirty);

  // R9: a stopped root yields no pulses
  assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    root_off |-> !out_en);
endmodule

bind clkroot_mux_div clkroot_mux_div_chk #(
  .NSRC(NSRC), .SRC_W(SRC_W), .DIV_W(DIV_W)
) u_chk (
  .clk_i(clk_i), .rst_n(rst_int_n), .src_en(src_en_i), .out_en(out_en_o),
  .upd(upd_w), .dirty(dirty_w), .cfg_we(cfg_we_w), .frame_end(frame_end_w),
  .root_off(root_off_w), .act_src(act_src_w), .act_div(act_div_w)
);

// File: tb/sim_clkroot_mux_div.sv
module sim_clkroot_mux_div;
  localparam int NSRC = 4;
  localparam int TMO  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] src_en;
  logic reg_we;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic out_en, root_off, dirty;

  always #5 clk = ~clk;

  clkroot_mux_div #(.NSRC(NSRC), .ROOT_TMO(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .out_en_o(out_en), .root_off_o(root_off), .dirty_o(dirty)
  );

  typedef struct { logic v; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // requirement model state
  int m_cnt = 0, m_idle = 0, m_asrc = 0, m_adiv = 1, m_psrc = 0, m_pdiv = 1;
  logic m_upd = 0, m_dirty = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NSRC-1:0] en, input logic we, input logic [3:0] addr,
                      input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd;
    logic tick, ro, fe, hit, apply;
    int n, ns, nd;
    @(negedge clk);
    src_en = en; reg_we = we; reg_addr = addr; reg_wdata = wd;
    #1;
    ro = (m_idle == TMO);
    if (!we) begin
      if (addr == 4'h0)      exp_rd = {ro, 26'd0, m_dirty, 3'd0, m_upd};
      else if (addr == 4'h4) exp_rd = (32'(m_psrc) << 8) | 32'(m_pdiv);
      else                   exp_rd = 32'd0;
      chk(reg_rdata == exp_rd, tag, reg_rdata, exp_rd);
    end
    chk(root_off == ro, {tag, " root_off"}, 32'(root_off), 32'(ro));
    chk(dirty == m_dirty, {tag, " dirty"}, 32'(dirty), 32'(m_dirty));
    n     = ((m_adiv == 0) ? 1 : m_adiv) + 1;
    tick  = (m_asrc < NSRC) ? en[m_asrc] : 1'b0;
    fe    = tick && (m_cnt == n - 1);
    hit   = tick && ((m_cnt == n / 2 - 1) || (m_cnt == n - 1));
    apply = m_upd && (fe || ro);
    if (tick) m_cnt = fe ? 0 : m_cnt + 1;
    if (apply) begin
      m_asrc = m_psrc; m_adiv = m_pdiv; m_cnt = 0; m_upd = 0; m_dirty = 0;
    end
    if (tick || apply) m_idle = 0;
    else if (m_idle < TMO) m_idle++;
    if (we && addr == 4'h0 && wd[0]) m_upd = 1;
    if (we && addr == 4'h4) begin
      ns = int'(wd[10:8]); nd = int'(wd[4:0]);
      if (ns != m_psrc || nd != m_pdiv) m_dirty = 1;
      m_psrc = ns; m_pdiv = nd;
    end
    sb.push_back('{hit, tag});
  endtask

  task automatic run(input int cycles, input logic [NSRC-1:0] mask, input int period, input string tag);
    for (int i = 0; i < cycles; i++)
      step((i % period == 0) ? mask : '0, 1'b0, 4'h0, 32'd0, tag);
  endtask

  task automatic wr(input logic [3:0] addr, input logic [31:0] wd, input logic [NSRC-1:0] en);
    step(en, 1'b1, addr, wd, "write");
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(out_en == e.v, {e.tag, " out_en"}, 32'(out_en), 32'(e.v));
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_en = '0; reg_we = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state, R2 unmapped offset
    step('0, 0, 4'h0, 0, "R1 cmd");
    step('0, 0, 4'h4, 0, "R1 cfg");
    step('0, 0, 4'h8, 0, "R2 unmapped");
    run(8, 4'b0001, 1, "R10 div1");
    // R2/R3: stray bits ignored, pending readback, rate unchanged
    wr(4'h4, 32'hFFFF_F8E3, 4'b0001);
    step(4'b0001, 0, 4'h4, 0, "R3 pending");
    step(4'b0001, 0, 4'h0, 0, "R4 dirty set");
    // R5: bit0 clear and read-only bits have no effect
    wr(4'h0, 32'h8000_0010, 4'b0001);
    step(4'b0001, 0, 4'h0, 0, "R5 no request");
    run(4, 4'b0001, 1, "R3 old rate");
    // R7: request mid-frame, applied at frame end
    wr(4'h0, 32'h1, 4'b0001);
    run(10, 4'b0001, 1, "R7 apply");
    run(12, 4'b0001, 1, "R6 div2");
    wr(4'h4, 32'h2, 4'b0001);
    wr(4'h0, 32'h1, 4'b0001);
    run(14, 4'b0001, 1, "R6 div1.5");
    // R4: same value write while clean
    wr(4'h4, 32'h2, 4'b0001);
    step(4'b0001, 0, 4'h0, 0, "R4 same value");
    wr(4'h4, 32'h4, 4'b0001);
    wr(4'h0, 32'h1, 4'b0001);
    run(30, 4'b0001, 2, "R6 div2.5");
    wr(4'h4, 32'h0, 4'b0001);
    wr(4'h0, 32'h1, 4'b0001);
    run(10, 4'b0001, 1, "R6 code0");
    // R8: source 2 selected while source 0 keeps ticking
    wr(4'h4, 32'h0000_0201, 4'b0001);
    wr(4'h0, 32'h1, 4'b0001);
    for (int i = 0; i < 24; i++)
      step({1'b0, (i % 3 == 0), 1'b0, 1'b1}, 0, 4'h0, 0, "R8 src2");
    // R8: index without a source
    wr(4'h4, 32'h0000_0501, 4'b1111);
    wr(4'h0, 32'h1, 4'b1111);
    run(6, 4'b1111, 1, "R8 empty index");
    // R9: root stops, then a redirect is applied at once
    run(20, 4'b1111, 1, "R9 root off");
    wr(4'h4, 32'h1, 4'b0000);
    wr(4'h0, 32'h1, 4'b0000);
    run(3, 4'b0000, 1, "R9 immediate apply");
    run(6, 4'b0001, 1, "R9 restart");
    step('0, 0, 4'h0, 0, "R9 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule